// File: doc/BRIEF.md
# Indirect Branch Landing Pad Checker

This block sits in the decode or execute stage of a simple in-order pipeline and enforces landing-pad discipline after indirect register branches. Each instruction arrives as one beat on a valid/ready stream. The beat carries a decoded class, a landing-pad type field, the guarded attribute of the page the instruction was fetched from, and an opaque tag such as the PC. A global protection enable bit sits beside the stream.

When an indirect jump or indirect call is accepted, the block remembers which kind it was. The next accepted instruction is checked against that record. If protection is on, the instruction lies on a guarded page, and it is not a landing pad whose type accepts the remembered branch kind, the block drops the beat and raises a single-cycle branch-target exception. The exception carries a syndrome that names the pending branch kind. In every other case the beat passes through unchanged, and a landing pad then acts as a no-op.

The stream is a combinational pass-through. Back-pressure from the consumer reaches the producer directly, and a cycle with no handshake changes no state.

Top module: `lpc_landing_checker`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) no branch check is pending, so the first accepted instruction never raises an exception.
- R2: A beat is accepted when in_valid and in_ready are both high. An accepted beat with in_kind 1 (indirect jump) or 2 (indirect call) makes the next accepted beat subject to the check. When that beat violates the check, exc_valid is high in the same cycle, exc_syndrome is 01 for a pending jump or 10 for a pending call, and out_valid is low.
- R3: in_pad_type bit 0 accepts calls and bit 1 accepts jumps, so 01 is a call pad, 10 is a jump pad and 11 accepts both. A landing pad (in_kind 3) passes a pending call only with type 01 or 11, and a pending jump only with type 10 or 11. Type 00 never passes.
- R4: When the checked beat has in_guarded low or prot_en low, no exception is raised and the beat passes unchanged.
- R5: Cycles without an accepted beat leave the pending state unchanged, whether in_valid is low or out_ready is low.
- R6: Once a beat has been checked, the pending state is cleared unless that beat is itself an indirect branch that did not fault. A faulting beat always clears the pending state. A landing pad with nothing pending passes with no exception.
- R7: in_ready equals out_ready, and out_tag equals in_tag. out_valid equals in_valid except in a violating cycle. exc_valid and exc_syndrome are zero in every cycle without an accepted violating beat.
- R8: An indirect branch that follows another indirect branch and passes the check (unguarded page or protection off) arms a new check of its own kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prot_en | input | 1 | Branch protection enable |
| in_valid | input | 1 | Instruction beat valid |
| in_ready | output | 1 | Instruction beat ready |
| in_kind | input | 2 | 0 other, 1 indirect jump, 2 indirect call, 3 landing pad |
| in_pad_type | input | 2 | Landing-pad accept bits: bit 0 call, bit 1 jump |
| in_guarded | input | 1 | Guarded attribute of the instruction's page |
| in_tag | input | TAG_W | Opaque payload carried with the beat |
| out_valid | output | 1 | Forwarded beat valid |
| out_ready | input | 1 | Consumer ready |
| out_tag | output | TAG_W | Forwarded payload |
| exc_valid | output | 1 | Branch-target exception pulse |
| exc_syndrome | output | 2 | Pending branch kind on exception: 01 jump, 10 call |

## Verification
Directed sequences pair each pending kind with each landing-pad type and with non-pad instructions. This separates a correct compatibility table from one that swaps the call and jump bits or accepts type 00. Stalls inserted between a branch and its target, by dropping either valid or ready, distinguish a state that holds across idle cycles from one that clears on any clock. Targets on unguarded pages, with protection off, and chains of back-to-back branches show that the gate uses the target's attributes and that a passing branch re-arms the check. A long seeded random run mixes all of these against a bench model of the pending state.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam logic [1:0] KIND_OTHER = 2'd0;
  localparam logic [1:0] KIND_IJMP  = 2'd1;
  localparam logic [1:0] KIND_ICALL = 2'd2;
  localparam logic [1:0] KIND_PAD   = 2'd3;

  localparam int PAD_CALL_BIT = 0;
  localparam int PAD_JUMP_BIT = 1;

  typedef enum logic [1:0] {
    PEND_NONE = 2'b00,
    PEND_JUMP = 2'b01,
    PEND_CALL = 2'b10
  } pend_e;
endpackage

// File: rtl/lpc_pad_match.sv
module lpc_pad_match
  import lpc_pkg::*;
(
  input  pend_e      pend,
  input  logic [1:0] kind,
  input  logic [1:0] pad_type,
  output logic       accept
);
  always_comb begin
    accept = 1'b0;
    if (kind == KIND_PAD) begin
      unique case (pend)
        PEND_JUMP: accept = pad_type[PAD_JUMP_BIT];
        PEND_CALL: accept = pad_type[PAD_CALL_BIT];
        default:   accept = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/lpc_pend_state.sv
module lpc_pend_state
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       fault,
  input  logic [1:0] kind,
  output pend_e      pend_q
);
  pend_e pend_d;

  always_comb begin
    pend_d = pend_q;
    if (fire) begin
      if (fault)                   pend_d = PEND_NONE;
      else if (kind == KIND_IJMP)  pend_d = PEND_JUMP;
      else if (kind == KIND_ICALL) pend_d = PEND_CALL;
      else                         pend_d = PEND_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= PEND_NONE;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/lpc_landing_checker.sv
module lpc_landing_checker
  import lpc_pkg::*;
#(
  parameter int TAG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [1:0]       in_pad_type,
  input  logic             in_guarded,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TAG_W-1:0] out_tag,
  output logic             exc_valid,
  output logic [1:0]       exc_syndrome
);
  pend_e pend_q;
  logic  pad_ok;
  logic  fire;
  logic  enforce;
  logic  violation;

  assign in_ready = out_ready;
  assign fire     = in_valid && out_ready;

  lpc_pad_match u_match (
    .pend     (pend_q),
    .kind     (in_kind),
    .pad_type (in_pad_type),
    .accept   (pad_ok)
  );

  assign enforce   = prot_en && in_guarded && (pend_q != PEND_NONE);
  assign violation = enforce && !pad_ok;

  lpc_pend_state u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .fault  (violation),
    .kind   (in_kind),
    .pend_q (pend_q)
  );

  assign out_valid    = in_valid && !violation;
  assign out_tag      = in_tag;
  assign exc_valid    = fire && violation;
  assign exc_syndrome = exc_valid ? pend_q : 2'b00;
endmodule

// File: rtl/lpc_landing_checker_sva.sv
module lpc_landing_checker_sva
  import lpc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       prot_en,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_kind,
  input logic       in_guarded,
  input logic       out_valid,
  input logic       exc_valid,
  input logic [1:0] exc_syndrome,
  input pend_e      pend_q
);
  logic fire_w;
  assign fire_w = in_valid && in_ready;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> pend_q == PEND_NONE) else $error("R1");  // R1
  AST_EXC_DROPS_BEAT: assert property (@(posedge clk) disable iff (!rst_n) exc_valid |-> !out_valid && exc_syndrome != 2'b00) else $error("R2");  // R2
  AST_EXC_GATED: assert property (@(posedge clk) disable iff (!rst_n) exc_valid |-> prot_en && in_guarded) else $error("R4");  // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !fire_w |=> $stable(pend_q)) else $error("R5");  // R5
  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) exc_valid |=> pend_q == PEND_NONE) else $error("R6");  // R6
  AST_SYN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(exc_syndrome) && (exc_valid || exc_syndrome == 2'b00)) else $error("R7");  // R7
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n) fire_w && !exc_valid && in_kind == KIND_ICALL |=> pend_q == PEND_CALL) else $error("R8");  // R8
endmodule

bind lpc_landing_checker lpc_landing_checker_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .prot_en      (prot_en),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_kind      (in_kind),
  .in_guarded   (in_guarded),
  .out_valid    (out_valid),
  .exc_valid    (exc_valid),
  .exc_syndrome (exc_syndrome),
  .pend_q       (pend_q)
);

// File: tb/lpc_landing_checker_tb_top.sv
module lpc_landing_checker_tb_top;
  localparam int TAG_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             prot_en = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [1:0]       in_kind = 2'd0;
  logic [1:0]       in_pad_type = 2'd0;
  logic             in_guarded = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [TAG_W-1:0] out_tag;
  logic             exc_valid;
  logic [1:0]       exc_syndrome;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_pend = 2'b00;   // bench model: 00 none, 01 jump, 10 call
  bit finished = 0;

  always #5 clk = ~clk;

  lpc_landing_checker #(.TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_pad_type(in_pad_type), .in_guarded(in_guarded), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .exc_valid(exc_valid), .exc_syndrome(exc_syndrome)
  );

  function automatic bit exp_violation(logic [1:0] pend, logic [1:0] kind,
                                       logic [1:0] pt, logic g, logic p);
    bit ok;
    if (pend == 2'b00 || !g || !p) return 1'b0;
    ok = (kind == 2'd3) && ((pend == 2'b10) ? pt[0] : pt[1]);
    return !ok;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] kind, logic [1:0] pt, logic g, logic p,
                      logic v, logic r, string req);
    bit viol, fire;
    @(negedge clk);
    in_kind = kind; in_pad_type = pt; in_guarded = g; prot_en = p;
    in_valid = v; out_ready = r; in_tag = $urandom;
    #1;
    fire = v && r;
    viol = exp_violation(m_pend, kind, pt, g, p);
    check({req, " exc_valid"}, exc_valid, fire && viol);
    check({req, " exc_syndrome"}, exc_syndrome, (fire && viol) ? m_pend : 2'b00);
    check({req, " out_valid"}, out_valid, v && !viol);
    check("R7 in_ready", in_ready, r);
    check("R7 out_tag", out_tag, in_tag);
    if (fire) begin
      if (viol)            m_pend = 2'b00;
      else if (kind == 1)  m_pend = 2'b01;
      else if (kind == 2)  m_pend = 2'b10;
      else                 m_pend = 2'b00;
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7171));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; m_pend = 2'b00;
    // R1: first beat after reset, non-pad on guarded page, protection on
    step(0, 0, 1, 1, 1, 1, "R1");
    // R2: jump then other -> syndrome 01; call then other -> 10
    step(1, 0, 1, 1, 1, 1, "R2"); step(0, 0, 1, 1, 1, 1, "R2");
    step(2, 0, 1, 1, 1, 1, "R2"); step(0, 0, 1, 1, 1, 1, "R2");
    // R3: compatibility table
    for (int pk = 1; pk <= 2; pk++)
      for (int t = 0; t < 4; t++) begin
        step(pk[1:0], 0, 1, 1, 1, 1, "R3");
        step(2'd3, t[1:0], 1, 1, 1, 1, "R3");
      end
    // R4: unguarded target and protection off
    step(2, 0, 1, 1, 1, 1, "R4"); step(0, 0, 0, 1, 1, 1, "R4");
    step(1, 0, 1, 1, 1, 1, "R4"); step(3, 2'b01, 1, 0, 1, 1, "R4");
    // R5: stalls keep pending, then a violating beat
    step(2, 0, 1, 1, 1, 1, "R5"); step(0, 0, 1, 1, 0, 1, "R5");
    step(0, 0, 1, 1, 1, 0, "R5"); step(0, 0, 1, 1, 1, 1, "R5");
    // R6: pad with nothing pending; pending cleared after one check
    step(3, 0, 1, 1, 1, 1, "R6");
    step(1, 0, 1, 1, 1, 1, "R6"); step(3, 2'b10, 1, 1, 1, 1, "R6");
    step(0, 0, 1, 1, 1, 1, "R6");
    // R8: branch chain on unguarded page re-arms with new kind
    step(1, 0, 1, 1, 1, 1, "R8"); step(2, 0, 0, 1, 1, 1, "R8");
    step(3, 2'b10, 1, 1, 1, 1, "R8");
    // R2/R6: faulting branch clears state
    step(1, 0, 1, 1, 1, 1, "R6"); step(2, 0, 1, 1, 1, 1, "R6");
    step(0, 0, 1, 1, 1, 1, "R6");
    // R1: reset mid-pending
    step(2, 0, 1, 1, 1, 1, "R1");
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1; m_pend = 2'b00;
    step(0, 0, 1, 1, 1, 1, "R1");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] k;
      k = 2'($urandom_range(0, 3));
      step(k, 2'($urandom_range(0, 3)), ($urandom_range(0, 9) < 8),
           ($urandom_range(0, 9) < 8), ($urandom_range(0, 9) < 8),
           ($urandom_range(0, 9) < 8), "R2 R3 R5 random");
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule